// File: doc/BRIEF.md
# Real-Time Clock Control and Status Register

This block is the processor-side control and status logic of a real-time clock that talks over a 4-bit parallel bus. At address 0 a write loads four control latches, and a read returns two sticky status flags. These are two separate registers that share one address. The control latches drive the test-mode line, stop or run timekeeping, stop or run the interrupt timer, and choose which of two setup registers answers at address 15.

The two setup registers behind address 15 are the clock-setting register and the interrupt-configuration register. The clock-setting register holds the 12-hour mode bit, the AM/PM indicator and the 2-bit leap-year preset. The interrupt-configuration register holds the repeat/single mode bit and a 3-bit delay select. The block takes a one-cycle tick from the timekeeping chain, which sets the data-changed flag. It also takes a one-cycle timeout from the interrupt timer, which sets the interrupt flag and pulls the active-low interrupt output low. A read of address 0 clears both flags. The counters themselves are outside this block. While `clk_run_o` is low, the timekeeping chain holds its tenths counter at zero.

Top module: `rtc_ctrl_status`

## Requirements
- R1: After reset the controls are: test mode off, clock running, select 0, interrupt timer stopped. Both flags and both setup registers are 0, `irq_n_o` is 1, and a read of address 0 returns 0.
- R2: A write to address 0 loads the controls, and the outputs change after the write's clock edge. Bit 3 is test mode. Bit 2 is clock stop (1 stops, 0 runs). Bit 1 is select. Bit 0 is interrupt stop (1 stops).
- R3: `bus_rdata` follows `bus_rd` and `bus_addr` combinationally and is 0 when no read is requested. A read of address 0 returns the data-changed flag in bit 3 and the interrupt flag in bit 0, with bits 2 and 1 at 0. The read returns the flag values from before the clearing edge.
- R4: With select 0, address 15 writes and reads reach the clock-setting register. With select 1 they reach the interrupt-configuration register. The register that is not selected keeps its value.
- R5: In the clock-setting register, bit 0 drives `hr12_o`, bit 1 drives `pm_o`, and bits 3:2 drive `leap_o`.
- R6: Each `tick_i` pulse sets the data-changed flag. Only a read of address 0 clears it. Writes to any address and reads of other addresses leave it set.
- R7: A tick, or a timeout, arriving in the same cycle as an address-0 read leaves its flag set after that edge.
- R8: Each `irq_timeout_i` pulse sets the interrupt flag. `irq_n_o` is low exactly while the flag is set. An address-0 read clears the flag.
- R9: In the interrupt-configuration register, bit 3 = 1 selects repeat mode and bit 3 = 0 selects single mode. `irq_cfg_o` carries the whole register. A timeout in single mode sets interrupt stop, so `irq_run_o` falls, unless an address-0 write happens in the same cycle. In repeat mode `irq_run_o` stays high.
- R10: While the interrupt-configuration register is 0, interrupt stop is forced to 1, even when address 0 is written with bit 0 = 0.
- R11: Writing 0 to address 0 gives normal operation. The clock runs, test mode is off, address 15 reaches the clock-setting register, and the interrupt timer runs if its configuration is nonzero.
- R12: Writes to addresses other than 0 and 15 change no output, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 4 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 4 | Read data, combinational |
| tick_i | input | 1 | Time-advance pulse from the timekeeping chain |
| irq_timeout_i | input | 1 | Timeout pulse from the interrupt timer |
| clk_run_o | output | 1 | 1 = timekeeping runs; 0 = halted with tenths held at zero |
| test_mode_o | output | 1 | Test mode enable |
| irq_run_o | output | 1 | 1 = interrupt timer counts |
| hr12_o | output | 1 | 12-hour mode |
| pm_o | output | 1 | AM/PM indicator |
| leap_o | output | 2 | Leap-year counter preset |
| irq_cfg_o | output | 4 | Interrupt mode and delay select |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench targets the same-cycle collisions. If the clear were given priority over the set when a tick or timeout coincides with a status read, that event would be lost, and the next read would show 0 instead of the flag. The bench also checks that writes to address 0 and reads of address 15 leave the flags untouched. A design that decoded the clear on address alone, without the read strobe, would drop the flag on those accesses. The single-versus-repeat timeout and the forced stop under a zero configuration are checked as well. A design that ignored the mode bit, or let a bit-0 write restart a timer with no configured delay, would show the wrong `irq_run_o`.

// File: rtl/rtc_cs_pkg.sv
package rtc_cs_pkg;
  // control latch word, MSB first: matches write data bits 3..0
  typedef struct packed {
    logic test;
    logic clk_stop;
    logic sel;
    logic irq_stop;
  } ctrl_t;

  localparam int unsigned RB_DCHG  = 3;
  localparam int unsigned RB_IFLAG = 0;
  localparam int unsigned CB_HR12  = 0;
  localparam int unsigned CB_PM    = 1;
  localparam int unsigned CB_LEAP  = 2;
  localparam int unsigned CFG_MODE = 3;
  localparam int unsigned NSETUP   = 2;
endpackage

// File: rtl/rtc_cs_flag.sv
module rtc_cs_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  // set beats clear so a coincident event survives the read
  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rtc_cs_ctrl.sv
module rtc_cs_ctrl
  import rtc_cs_pkg::*;
#(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          timeout_i,
  input  logic          single_i,
  input  logic          cfg_zero_i,
  output ctrl_t         ctrl_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_en;

  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_en = we_i | (timeout_i & single_i) | cfg_zero_i;
    if (we_i) begin
      ctrl_d = ctrl_t'(wdata_i[3:0]);
    end else if (timeout_i && single_i) begin
      ctrl_d.irq_stop = 1'b1;
    end
    if (cfg_zero_i) ctrl_d.irq_stop = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.test     <= 1'b0;
      ctrl_q.clk_stop <= 1'b0;
      ctrl_q.sel      <= 1'b0;
      ctrl_q.irq_stop <= 1'b1;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/rtc_cs_bank.sv
module rtc_cs_bank
  import rtc_cs_pkg::*;
#(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] set_o,
  output logic [DW-1:0] cfg_o,
  output logic [DW-1:0] rd_o,
  output logic          cfg_zero_nxt_o
);
  logic [NSETUP-1:0][DW-1:0] reg_q;
  logic [NSETUP-1:0][DW-1:0] reg_d;
  logic [NSETUP-1:0]         reg_en;

  for (genvar g = 0; g < NSETUP; g++) begin : g_setup
    always_comb begin
      reg_en[g] = we_i & (sel_i == g[0]);
      reg_d[g]  = reg_en[g] ? wdata_i : reg_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         reg_q[g] <= '0;
      else if (reg_en[g]) reg_q[g] <= reg_d[g];
    end
  end

  assign set_o          = reg_q[0];
  assign cfg_o          = reg_q[1];
  assign rd_o           = reg_q[sel_i];
  assign cfg_zero_nxt_o = ~|reg_d[1];
endmodule

// File: rtl/rtc_ctrl_status.sv
module rtc_ctrl_status
  import rtc_cs_pkg::*;
#(
  parameter int unsigned DW         = 4,
  parameter int unsigned AW         = 4,
  parameter int unsigned CTRL_ADDR  = 0,
  parameter int unsigned STEER_ADDR = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_i,
  input  logic          irq_timeout_i,
  output logic          clk_run_o,
  output logic          test_mode_o,
  output logic          irq_run_o,
  output logic          hr12_o,
  output logic          pm_o,
  output logic [1:0]    leap_o,
  output logic [DW-1:0] irq_cfg_o,
  output logic          irq_n_o
);
  localparam logic [AW-1:0] A_CTRL  = AW'(CTRL_ADDR);
  localparam logic [AW-1:0] A_STEER = AW'(STEER_ADDR);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic ctrl_wr, ctrl_rd, steer_wr, steer_rd;
  always_comb begin
    ctrl_wr  = bus_wr & (bus_addr == A_CTRL);
    ctrl_rd  = bus_rd & (bus_addr == A_CTRL);
    steer_wr = bus_wr & (bus_addr == A_STEER);
    steer_rd = bus_rd & (bus_addr == A_STEER);
  end

  ctrl_t         ctrl;
  logic [DW-1:0] set_q, cfg_q, steer_q;
  logic          cfg_zero_nxt;
  logic          dchg_q, iflag_q;

  rtc_cs_bank #(.DW(DW)) bank_i (
    .clk            (clk),
    .rst_n          (rst_q),
    .we_i           (steer_wr),
    .sel_i          (ctrl.sel),
    .wdata_i        (bus_wdata),
    .set_o          (set_q),
    .cfg_o          (cfg_q),
    .rd_o           (steer_q),
    .cfg_zero_nxt_o (cfg_zero_nxt)
  );

  rtc_cs_ctrl #(.DW(DW)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_q),
    .we_i       (ctrl_wr),
    .wdata_i    (bus_wdata),
    .timeout_i  (irq_timeout_i),
    .single_i   (~cfg_q[CFG_MODE]),
    .cfg_zero_i (cfg_zero_nxt),
    .ctrl_o     (ctrl)
  );

  rtc_cs_flag dchg_i (
    .clk    (clk),
    .rst_n  (rst_q),
    .set_i  (tick_i),
    .clr_i  (ctrl_rd),
    .flag_o (dchg_q)
  );

  rtc_cs_flag iflag_i (
    .clk    (clk),
    .rst_n  (rst_q),
    .set_i  (irq_timeout_i),
    .clr_i  (ctrl_rd),
    .flag_o (iflag_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (ctrl_rd) begin
      bus_rdata[RB_DCHG]  = dchg_q;
      bus_rdata[RB_IFLAG] = iflag_q;
    end else if (steer_rd) begin
      bus_rdata = steer_q;
    end
  end

  assign clk_run_o   = ~ctrl.clk_stop;
  assign test_mode_o = ctrl.test;
  assign irq_run_o   = ~ctrl.irq_stop;
  assign hr12_o      = set_q[CB_HR12];
  assign pm_o        = set_q[CB_PM];
  assign leap_o      = set_q[CB_LEAP +: 2];
  assign irq_cfg_o   = cfg_q;
  assign irq_n_o     = ~iflag_q;
endmodule

// File: rtl/rtc_cs_checker.sv
module rtc_cs_checker #(
  parameter int unsigned DW = 4,
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_q,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          tick_i,
  input logic          irq_timeout_i,
  input logic          dchg_q,
  input logic          irq_n_o,
  input logic          irq_run_o,
  input logic [DW-1:0] cfg_q,
  input logic [DW-1:0] set_q
);
  logic rd0, wr0, wr15;
  assign rd0  = bus_rd && (bus_addr == '0);
  assign wr0  = bus_wr && (bus_addr == '0);
  assign wr15 = bus_wr && (bus_addr == '1);

  assert_dchg_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
    (dchg_q && !rd0) |=> dchg_q);

  assert_tick_wins_R7: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
    tick_i |=> dchg_q);

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
    (rd0 && !tick_i) |=> !dchg_q);

  assert_timeout_pin_R8: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
    irq_timeout_i |=> !irq_n_o);

  assert_cfg_zero_stop_R10: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
    (cfg_q == '0) |-> !irq_run_o);

  assert_single_stop_R9: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
    (irq_timeout_i && !cfg_q[DW-1] && !wr0) |=> !irq_run_o);

  assert_setup_stable_R4: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
    !wr15 |=> ($stable(set_q) && $stable(cfg_q)));
endmodule

bind rtc_ctrl_status rtc_cs_checker #(.DW(DW), .AW(AW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .rst_q         (rst_q),
  .bus_rd        (bus_rd),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .tick_i        (tick_i),
  .irq_timeout_i (irq_timeout_i),
  .dchg_q        (dchg_q),
  .irq_n_o       (irq_n_o),
  .irq_run_o     (irq_run_o),
  .cfg_q         (cfg_q),
  .set_q         (set_q)
);

// File: tb/rtc_ctrl_status_tb_top.sv
`timescale 1ns/1ps
module rtc_ctrl_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bus_addr, bus_wdata, bus_rdata, irq_cfg_o;
  logic       bus_wr, bus_rd, tick_i, irq_timeout_i;
  logic       clk_run_o, test_mode_o, irq_run_o, hr12_o, pm_o, irq_n_o;
  logic [1:0] leap_o;

  always #10 clk = ~clk;

  rtc_ctrl_status dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tick_i(tick_i), .irq_timeout_i(irq_timeout_i),
    .clk_run_o(clk_run_o), .test_mode_o(test_mode_o), .irq_run_o(irq_run_o),
    .hr12_o(hr12_o), .pm_o(pm_o), .leap_o(leap_o), .irq_cfg_o(irq_cfg_o),
    .irq_n_o(irq_n_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit       m_test, m_cstop, m_sel, m_istop, m_dchg, m_iflag;
  bit [3:0] m_set, m_cfg;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_test = 0; m_cstop = 0; m_sel = 0; m_istop = 1;
      m_dchg = 0; m_iflag = 0; m_set = 0; m_cfg = 0;
    end else begin
      bit rd0, wr0, wr15, old_sel;
      bit [3:0] old_cfg;
      rd0 = bus_rd && bus_addr == 0;
      wr0 = bus_wr && bus_addr == 0;
      wr15 = bus_wr && bus_addr == 15;
      old_sel = m_sel;
      old_cfg = m_cfg;
      m_dchg  = tick_i || (m_dchg && !rd0);
      m_iflag = irq_timeout_i || (m_iflag && !rd0);
      if (wr15) begin
        if (old_sel) m_cfg = bus_wdata; else m_set = bus_wdata;
      end
      if (wr0) {m_test, m_cstop, m_sel, m_istop} = bus_wdata;
      else if (irq_timeout_i && !old_cfg[3]) m_istop = 1;
      if (m_cfg == 0) m_istop = 1;
    end
  end

  function automatic logic [3:0] exp_rdata();
    if (!bus_rd) return 4'h0;
    if (bus_addr == 0) return {m_dchg, 2'b00, m_iflag};
    if (bus_addr == 15) return m_sel ? m_cfg : m_set;
    return 4'h0;
  endfunction

  // cycle-by-cycle compare, away from the active edge
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk("R2 clk_run",  {3'b0, clk_run_o},   {3'b0, !m_cstop});
      chk("R2 test",     {3'b0, test_mode_o}, {3'b0, m_test});
      chk("R9 irq_run",  {3'b0, irq_run_o},   {3'b0, !m_istop});
      chk("R5 setting",  {leap_o, pm_o, hr12_o}, m_set);
      chk("R4 irq_cfg",  irq_cfg_o, m_cfg);
      chk("R8 irq_n",    {3'b0, irq_n_o}, {3'b0, !m_iflag});
      chk("R3 rdata",    bus_rdata, exp_rdata());
    end
  end

  task automatic op(input bit wr, input bit rd, input logic [3:0] a,
                    input logic [3:0] d, input bit tk, input bit to);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    tick_i = tk; irq_timeout_i = to;
  endtask

  task automatic idle_settle();
    op(0, 0, 0, 0, 0, 0);
    #5;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [3:0] exp,
                        input bit tk = 0, input bit to = 0);
    op(0, 1, a, 0, tk, to);
    #5;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    tick_i = 0; irq_timeout_i = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) idle_settle();

    // R1 reset state
    chk("R1 clk_run", {3'b0, clk_run_o}, 4'h1);
    chk("R1 test",    {3'b0, test_mode_o}, 4'h0);
    chk("R1 irq_run", {3'b0, irq_run_o}, 4'h0);
    chk("R1 irq_n",   {3'b0, irq_n_o}, 4'h1);
    rd_chk("R1 status read", 0, 4'h0);

    // R2 control latches
    op(1, 0, 0, 4'b1101, 0, 0); idle_settle();
    chk("R2 test on",    {3'b0, test_mode_o}, 4'h1);
    chk("R2 clock stop", {3'b0, clk_run_o}, 4'h0);
    chk("R2 irq stop",   {3'b0, irq_run_o}, 4'h0);

    // R4 select 1 steers to interrupt configuration
    op(1, 0, 0, 4'b0010, 0, 0);
    op(1, 0, 15, 4'b1011, 0, 0); idle_settle();
    chk("R4 cfg written", irq_cfg_o, 4'b1011);
    chk("R4 setting kept", {leap_o, pm_o, hr12_o}, 4'h0);

    // R11 all-zero write
    op(1, 0, 0, 4'b0000, 0, 0); idle_settle();
    chk("R11 clk_run", {3'b0, clk_run_o}, 4'h1);
    chk("R11 test",    {3'b0, test_mode_o}, 4'h0);
    chk("R11 irq_run", {3'b0, irq_run_o}, 4'h1);
    rd_chk("R11 addr15 reaches setting", 15, 4'h0);

    // R5 setting fields
    op(1, 0, 15, 4'b1110, 0, 0); idle_settle();
    chk("R5 hr12", {3'b0, hr12_o}, 4'h0);
    chk("R5 pm",   {3'b0, pm_o}, 4'h1);
    chk("R5 leap", {2'b0, leap_o}, 4'h3);
    chk("R4 cfg unchanged", irq_cfg_o, 4'b1011);
    rd_chk("R4 read setting", 15, 4'b1110);

    // R6 data-changed flag survives other accesses
    op(0, 0, 0, 0, 1, 0);
    op(1, 0, 0, 4'b0000, 0, 0);
    op(0, 1, 15, 0, 0, 0);
    op(0, 1, 7, 0, 0, 0);
    rd_chk("R6 flag kept", 0, 4'b1000);
    rd_chk("R6 flag cleared", 0, 4'b0000);

    // R7 same-cycle set and read
    rd_chk("R7 read with tick", 0, 4'b0000, 1, 0);
    rd_chk("R7 tick kept", 0, 4'b1000, 0, 1);
    rd_chk("R7 timeout kept", 0, 4'b0001);

    // R8 interrupt flag and pin
    op(0, 0, 0, 0, 0, 1); idle_settle();
    chk("R8 pin low", {3'b0, irq_n_o}, 4'h0);
    chk("R9 repeat keeps running", {3'b0, irq_run_o}, 4'h1);
    rd_chk("R8 flag read", 0, 4'b0001);
    idle_settle();
    chk("R8 pin released", {3'b0, irq_n_o}, 4'h1);

    // R9 single mode stops on timeout
    op(1, 0, 0, 4'b0010, 0, 0);
    op(1, 0, 15, 4'b0011, 0, 0);
    op(1, 0, 0, 4'b0000, 0, 0); idle_settle();
    chk("R9 single armed", {3'b0, irq_run_o}, 4'h1);
    op(0, 0, 0, 0, 0, 1); idle_settle();
    chk("R9 single stopped", {3'b0, irq_run_o}, 4'h0);
    op(0, 1, 0, 0, 0, 0);
    op(1, 0, 0, 4'b0000, 0, 0); idle_settle();
    chk("R9 restarted", {3'b0, irq_run_o}, 4'h1);

    // R10 zero configuration forces stop
    op(1, 0, 0, 4'b0010, 0, 0);
    op(1, 0, 15, 4'b0000, 0, 0); idle_settle();
    chk("R10 forced stop", {3'b0, irq_run_o}, 4'h0);
    op(1, 0, 0, 4'b0010, 0, 0); idle_settle();
    chk("R10 stays stopped", {3'b0, irq_run_o}, 4'h0);
    op(1, 0, 0, 4'b0000, 0, 0); idle_settle();
    chk("R10 zero write no start", {3'b0, irq_run_o}, 4'h0);

    // R12 other addresses
    op(1, 0, 7, 4'b1111, 0, 0); idle_settle();
    chk("R12 clk_run", {3'b0, clk_run_o}, 4'h1);
    chk("R12 test",    {3'b0, test_mode_o}, 4'h0);
    chk("R12 setting", {leap_o, pm_o, hr12_o}, 4'b1110);
    rd_chk("R12 read other", 7, 4'h0);

    // mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      int sel;
      sel = $urandom_range(0, 3);
      a = (sel == 0) ? 4'd0 : (sel == 1) ? 4'd15 : (sel == 2) ? 4'd7 : 4'd3;
      if ($urandom_range(0, 1) == 1)
        op(1, 0, a, 4'($urandom_range(0, 15)), $urandom_range(0, 3) == 0,
           $urandom_range(0, 4) == 0);
      else
        op(0, $urandom_range(0, 1) == 1, a, 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 4) == 0);
    end
    repeat (3) idle_settle();
    finish_run();
  end
endmodule